// File: doc/BRIEF.md
# Two-Channel Disk Controller I/O Window Decoder

This block sits between a host I/O port and the register targets of a two-channel disk controller. Each host access carries an address, a size and write data. The block compares the address against five programmable base windows:

- primary command
- primary control
- secondary command
- secondary control
- a shared 16-byte DMA-engine window

It then raises a one-hot select strobe toward the first window that claims the access. The strobe carries the offset relative to that window, together with the size, the direction and the data.

The block also keeps the state that decides whether an access reaches a target:

- an I/O decode enable and a DMA enable, both taken from a command-register write;
- the five base registers;
- for each channel, a bit that records which of its two drives is currently addressed.

Every access gets a registered response one cycle later. That response is a done pulse, and it may carry a size error, an unmatched-address error or a "no drive" flag.

Top module: `ide_io_decode`

## Requirements
- R1: An access whose size is not 1, 2 or 4 bytes produces `rsp_done` with `rsp_err_size`=1, raises no strobe and changes no state. The size check takes precedence over every other rule, including a disabled decoder.
- R2: After reset both enables are 0. A command write sets the I/O enable from bit 0 and the DMA enable from bit 2. While the I/O enable is 0, an access produces only `rsp_done`: no strobe and no error.
- R3: When windows overlap, the access goes to the first match in this order: primary command, primary control, secondary command, secondary control, DMA window.
- R4: A window matches when base ≤ address < base + size. The sizes are 8 bytes for command, 4 bytes for control and 16 bytes for the DMA window. `tgt_off` is the address minus the base.
- R5: DMA-window offsets 0–7 raise `tgt_sel[4]` (primary) with the offset unchanged. Offsets 8–15 raise `tgt_sel[5]` (secondary) with the offset minus 8. `tgt_sel` bits 0–3 are, in order, primary command, primary control, secondary command and secondary control.
- R6: While the DMA enable is 0, a write to the DMA window completes with no strobe and no error. Reads of the DMA window are still forwarded.
- R7: A 1-byte write at command-window offset 6 sets that channel's drive bit from data bit 4 (0 = first drive, 1 = second drive). The access is then forwarded on behalf of the new drive. `tgt_drive` reports the channel's drive bit on command and control strobes and reads 0 for the DMA window. Writes of any other size leave the drive bit unchanged.
- R8: A base write (index 0–4, in the R3 order) takes effect only when the value is nonzero. An access in the same cycle as a base or command write is decoded with the old values.
- R9: An enabled, well-sized access that matches no window produces `rsp_done` with `rsp_err_addr`=1 and no strobe.
- R10: `drive_present` bit 2·channel+drive marks which drives exist. A command- or control-window access whose addressed drive is absent raises `rsp_null` (reads return zero, writes are dropped) and no strobe.
- R11: All responses appear exactly one cycle after `acc_valid`. `rsp_done` pulses once per access and is 0 in idle cycles and after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Command-register write strobe |
| cfg_cmd | input | 16 | Command-register value (bit 0 I/O enable, bit 2 DMA enable) |
| base_we | input | 1 | Base-register write strobe |
| base_idx | input | 3 | Base index: 0 pri cmd, 1 pri ctl, 2 sec cmd, 3 sec ctl, 4 DMA |
| base_val | input | AW | New base address |
| acc_valid | input | 1 | Host access present this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | AW | Access address |
| acc_size | input | 3 | Access size in bytes |
| acc_wdata | input | 32 | Write data |
| drive_present | input | 4 | Drive exists, index 2·channel+drive |
| rsp_done | output | 1 | Access completed |
| rsp_err_size | output | 1 | Illegal size |
| rsp_err_addr | output | 1 | No window matched |
| rsp_null | output | 1 | Addressed drive absent |
| tgt_sel | output | 6 | One-hot target strobe |
| tgt_off | output | AW | Window-relative offset |
| tgt_size | output | 3 | Forwarded size |
| tgt_wdata | output | 32 | Forwarded write data |
| tgt_write | output | 1 | Forwarded direction |
| tgt_drive | output | 1 | Drive bit of the addressed channel |

## Verification
Two things can share a cycle: a configuration update (a base or command write) and a host access. The rule is that the access sees the state from before the update. The bench provokes this by issuing a base move and an enable clear in the same cycle as an access to the affected window. It then repeats the access in the next cycle, expecting the old decode first and the new one after. The drive-select write is the second case where a state change and a decode coincide. The bench judges it by the drive bit and the presence outcome reported on that same access.

// File: rtl/ide_io_decode.sv
module ide_io_decode #(
  parameter int AW     = 16,
  parameter int CMD_SZ = 8,
  parameter int CTL_SZ = 4,
  parameter int BM_SZ  = 16,
  parameter int SEL_OFF = 6,
  parameter int SEL_BIT = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [15:0]   cfg_cmd,
  input  logic          base_we,
  input  logic [2:0]    base_idx,
  input  logic [AW-1:0] base_val,
  input  logic          acc_valid,
  input  logic          acc_write,
  input  logic [AW-1:0] acc_addr,
  input  logic [2:0]    acc_size,
  input  logic [31:0]   acc_wdata,
  input  logic [3:0]    drive_present,
  output logic          rsp_done,
  output logic          rsp_err_size,
  output logic          rsp_err_addr,
  output logic          rsp_null,
  output logic [5:0]    tgt_sel,
  output logic [AW-1:0] tgt_off,
  output logic [2:0]    tgt_size,
  output logic [31:0]   tgt_wdata,
  output logic          tgt_write,
  output logic          tgt_drive
);
  localparam int NWIN = 5;
  localparam int BM_HALF = BM_SZ / 2;
  localparam logic [2:0] NOWIN = 3'd7;

  logic          io_en_q, bm_en_q;
  logic [1:0]    dsel_q, dsel_d;
  logic [AW-1:0] base_q [NWIN];
  logic [AW-1:0] offs [NWIN];
  logic [NWIN-1:0] hit;
  logic [2:0]    win;
  logic          size_ok, ch, drv_d, esz_d, ead_d, null_d;
  logic [5:0]    sel_d;
  logic [AW-1:0] off_d;

  function automatic logic [AW-1:0] win_size(input int i);
    case (i)
      0, 2:    return AW'(CMD_SZ);
      1, 3:    return AW'(CTL_SZ);
      default: return AW'(BM_SZ);
    endcase
  endfunction

  assign size_ok = (acc_size == 3'd1) || (acc_size == 3'd2) || (acc_size == 3'd4);

  always_comb begin
    for (int i = 0; i < NWIN; i++) begin
      offs[i] = acc_addr - base_q[i];
      hit[i]  = (acc_addr >= base_q[i]) && (offs[i] < win_size(i));
    end
    win = NOWIN;
    for (int i = NWIN - 1; i >= 0; i--)
      if (hit[i]) win = 3'(i);
  end

  always_comb begin
    sel_d  = '0;
    off_d  = '0;
    esz_d  = 1'b0;
    ead_d  = 1'b0;
    null_d = 1'b0;
    drv_d  = 1'b0;
    dsel_d = dsel_q;
    ch     = win[1];
    if (acc_valid) begin
      if (!size_ok) esz_d = 1'b1;
      else if (io_en_q) begin
        if (win == NOWIN) ead_d = 1'b1;
        else if (win == 3'd4) begin
          if (!acc_write || bm_en_q) begin
            if (offs[4] < AW'(BM_HALF)) begin
              sel_d[4] = 1'b1;
              off_d    = offs[4];
            end else begin
              sel_d[5] = 1'b1;
              off_d    = offs[4] - AW'(BM_HALF);
            end
          end
        end else begin
          if (!win[0] && acc_write && acc_size == 3'd1 && offs[win] == AW'(SEL_OFF))
            dsel_d[ch] = acc_wdata[SEL_BIT];
          drv_d = dsel_d[ch];
          if (drive_present[{ch, drv_d}]) begin
            sel_d[win] = 1'b1;
            off_d      = offs[win];
          end else null_d = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      io_en_q <= 1'b0;
      bm_en_q <= 1'b0;
      dsel_q  <= '0;
      for (int i = 0; i < NWIN; i++) base_q[i] <= '0;
      rsp_done <= 1'b0; rsp_err_size <= 1'b0; rsp_err_addr <= 1'b0; rsp_null <= 1'b0;
      tgt_sel <= '0; tgt_off <= '0; tgt_size <= '0; tgt_wdata <= '0;
      tgt_write <= 1'b0; tgt_drive <= 1'b0;
    end else begin
      if (cfg_we) begin
        io_en_q <= cfg_cmd[0];
        bm_en_q <= cfg_cmd[2];
      end
      if (base_we && base_val != '0 && base_idx < 3'(NWIN))
        base_q[base_idx] <= base_val;
      dsel_q       <= dsel_d;
      rsp_done     <= acc_valid;
      rsp_err_size <= esz_d;
      rsp_err_addr <= ead_d;
      rsp_null     <= null_d;
      tgt_sel      <= sel_d;
      tgt_off      <= off_d;
      tgt_size     <= acc_size;
      tgt_wdata    <= acc_wdata;
      tgt_write    <= acc_valid & acc_write;
      tgt_drive    <= drv_d;
    end
  end

  p_done_after_access_r11: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> rsp_done);
  p_quiet_when_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> !rsp_done && tgt_sel == '0);
  p_single_target_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tgt_sel));
  p_size_err_blocks_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err_size |-> tgt_sel == '0 && !rsp_err_addr && !rsp_null);
  p_cmd_off_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_sel[0] || tgt_sel[2]) |-> tgt_off < AW'(CMD_SZ));
  p_bm_half_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_sel[4] || tgt_sel[5]) |-> tgt_off < AW'(BM_HALF));
  p_bm_write_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((tgt_sel[4] || tgt_sel[5]) && tgt_write) |-> $past(bm_en_q));
  p_null_no_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_null |-> tgt_sel == '0 && !rsp_err_addr);
endmodule

// File: tb/sim_ide_io_decode.sv
`timescale 1ns/1ps
module sim_ide_io_decode;
  logic clk = 0, rst_n = 0;
  logic cfg_we = 0, base_we = 0, acc_valid = 0, acc_write = 0;
  logic [15:0] cfg_cmd = 0;
  logic [2:0] base_idx = 0, acc_size = 0;
  logic [15:0] base_val = 0, acc_addr = 0;
  logic [31:0] acc_wdata = 0;
  logic [3:0] drive_present = 4'hF;
  logic rsp_done, rsp_err_size, rsp_err_addr, rsp_null, tgt_write, tgt_drive;
  logic [5:0] tgt_sel;
  logic [15:0] tgt_off;
  logic [2:0] tgt_size;
  logic [31:0] tgt_wdata;

  ide_io_decode u0 (.*);

  always #5 clk = ~clk;

  int n_run = 0, n_fail = 0;
  int m_base[5];
  bit m_io = 0, m_bm = 0;
  bit m_dsel[2];
  bit e_done = 0, e_es = 0, e_ea = 0, e_nl = 0, e_drv = 0, e_wr = 0;
  int e_sel = 0, e_off = 0, e_sz = 0;
  logic [31:0] e_wd = 0;
  string e_rq = "R11";

  function automatic int wsz(int i);
    return (i == 4) ? 16 : ((i % 2 == 0) ? 8 : 4);
  endfunction

  task automatic check();
    bit bad;
    n_run++;
    bad = (rsp_done != e_done) || (rsp_err_size != e_es) || (rsp_err_addr != e_ea) ||
          (rsp_null != e_nl) || (int'(tgt_sel) != e_sel);
    if (e_sel != 0)
      bad = bad || (int'(tgt_off) != e_off) || (tgt_drive != e_drv) || (tgt_write != e_wr) ||
            (int'(tgt_size) != e_sz) || (tgt_wdata != e_wd);
    if (bad) begin
      n_fail++;
      $display("FAIL %s: got done=%0b es=%0b ea=%0b nl=%0b sel=%0h off=%0h drv=%0b wr=%0b | exp done=%0b es=%0b ea=%0b nl=%0b sel=%0h off=%0h drv=%0b wr=%0b",
        e_rq, rsp_done, rsp_err_size, rsp_err_addr, rsp_null, tgt_sel, tgt_off, tgt_drive, tgt_write,
        e_done, e_es, e_ea, e_nl, e_sel, e_off, e_drv, e_wr);
    end
  endtask

  task automatic step(input bit av, input bit aw, input int addr, input int sz, input logic [31:0] wd,
                      input bit cw, input int cd, input bit bw, input int bi, input int bd, input string rq);
    int w, c, o;
    @(negedge clk);
    check();
    acc_valid = av; acc_write = aw; acc_addr = 16'(addr); acc_size = 3'(sz); acc_wdata = wd;
    cfg_we = cw; cfg_cmd = 16'(cd); base_we = bw; base_idx = 3'(bi); base_val = 16'(bd);
    e_done = av; e_es = 0; e_ea = 0; e_nl = 0; e_drv = 0; e_sel = 0; e_off = 0;
    e_wr = av && aw; e_sz = sz; e_wd = wd; e_rq = rq;
    if (av) begin
      if (!(sz == 1 || sz == 2 || sz == 4)) e_es = 1;
      else if (m_io) begin
        w = -1;
        for (int i = 0; i < 5; i++)
          if (w < 0 && addr >= m_base[i] && addr - m_base[i] < wsz(i)) w = i;
        if (w < 0) e_ea = 1;
        else if (w == 4) begin
          if (!aw || m_bm) begin
            o = addr - m_base[4];
            if (o < 8) begin e_sel = 16; e_off = o; end
            else begin e_sel = 32; e_off = o - 8; end
          end
        end else begin
          c = w / 2; o = addr - m_base[w];
          if (w % 2 == 0 && aw && sz == 1 && o == 6) m_dsel[c] = wd[4];
          e_drv = m_dsel[c];
          if (drive_present[c * 2 + int'(e_drv)]) begin e_sel = 1 << w; e_off = o; end
          else e_nl = 1;
        end
      end
    end
    if (cw) begin m_io = cd[0]; m_bm = cd[2]; end
    if (bw && bd != 0 && bi < 5) m_base[bi] = bd;
  endtask

  task automatic acc(input bit aw, input int addr, input int sz, input logic [31:0] wd, input string rq);
    step(1, aw, addr, sz, wd, 0, 0, 0, 0, 0, rq);
  endtask
  task automatic setcmd(input int cd, input string rq);
    step(0, 0, 0, 1, 0, 1, cd, 0, 0, 0, rq);
  endtask
  task automatic setbase(input int bi, input int bd, input string rq);
    step(0, 0, 0, 1, 0, 0, 0, 1, bi, bd, rq);
  endtask

  bit wd_hit = 0;
  initial begin
    #2000000;
    wd_hit = 1;
    n_fail++;
    $display("FAIL watchdog: got no end, expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 5; i++) m_base[i] = 0;
    m_dsel[0] = 0; m_dsel[1] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    step(0, 0, 0, 1, 0, 0, 0, 0, 0, 0, "R11");
    acc(0, 16'h1F0, 1, 0, "R2");
    acc(0, 16'h1F0, 3, 0, "R1");
    setcmd(16'h0001, "R2");
    acc(0, 3, 1, 0, "R3");
    acc(0, 9, 2, 0, "R5");
    setbase(0, 16'h1F0, "R8");
    setbase(1, 16'h3F4, "R8");
    setbase(2, 16'h170, "R8");
    setbase(3, 16'h374, "R8");
    setbase(4, 16'hC000, "R8");
    setbase(0, 0, "R8");
    acc(0, 16'h1F0, 2, 0, "R8");
    acc(0, 16'h1F7, 1, 0, "R4");
    acc(1, 16'h1F8, 1, 32'h55, "R9");
    acc(0, 16'h3F6, 1, 0, "R4");
    acc(0, 16'h172, 2, 0, "R4");
    acc(1, 16'h377, 1, 32'hA5, "R4");
    acc(0, 16'h378, 1, 0, "R9");
    acc(0, 16'hC002, 1, 0, "R5");
    acc(1, 16'hC00A, 1, 32'h3, "R6");
    acc(0, 16'hC00A, 4, 0, "R6");
    setcmd(16'h0005, "R6");
    acc(1, 16'hC00A, 1, 32'h3, "R6");
    acc(1, 16'hC004, 4, 32'h12345678, "R5");
    acc(0, 16'hC010, 1, 0, "R9");
    acc(1, 16'h1F6, 1, 32'h10, "R7");
    acc(0, 16'h1F0, 1, 0, "R7");
    acc(1, 16'h1F6, 2, 32'h00, "R7");
    acc(0, 16'h3F4, 1, 0, "R7");
    acc(1, 16'h176, 1, 32'h10, "R7");
    acc(0, 16'h374, 1, 0, "R7");
    drive_present = 4'b1101;
    acc(0, 16'h1F0, 1, 0, "R10");
    acc(1, 16'h3F4, 1, 32'h1, "R10");
    acc(1, 16'h1F6, 1, 32'h00, "R10");
    acc(1, 16'h1F6, 1, 32'h10, "R10");
    acc(1, 16'h1F6, 1, 32'hEF, "R7");
    drive_present = 4'b0111;
    acc(0, 16'h172, 1, 0, "R10");
    acc(0, 16'h377, 1, 0, "R10");
    acc(0, 16'hC00C, 1, 0, "R10");
    drive_present = 4'hF;
    setbase(3, 16'h1F4, "R8");
    acc(0, 16'h1F5, 1, 0, "R3");
    setbase(2, 16'h3F0, "R8");
    acc(0, 16'h3F5, 1, 0, "R3");
    acc(0, 16'h3F1, 1, 0, "R3");
    step(1, 0, 16'h3F5, 1, 0, 0, 0, 1, 1, 16'h500, "R8");
    acc(0, 16'h3F5, 1, 0, "R8");
    acc(0, 16'h500, 1, 0, "R8");
    setbase(7, 16'h1234, "R8");
    acc(0, 16'h1F0, 1, 0, "R8");
    acc(0, 16'h1F0, 0, 0, "R1");
    acc(1, 16'h1F0, 5, 32'h10, "R1");
    acc(0, 16'h1F6, 1, 0, "R1");
    step(1, 0, 16'h3F2, 1, 0, 1, 16'h0004, 0, 0, 0, "R2");
    acc(0, 16'h3F2, 1, 0, "R2");
    acc(1, 16'h9999, 4, 0, "R2");
    acc(0, 16'h1F0, 6, 0, "R1");
    step(0, 0, 0, 1, 0, 0, 0, 0, 0, 0, "R11");
    step(0, 0, 0, 1, 0, 0, 0, 0, 0, 0, "R11");
    if (!wd_hit) begin
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule